// File: doc/BRIEF.md
# Pulse-Pause Frame Transmitter

This block sends a short reader-to-tag frame by switching a carrier on and off. Each data bit opens with a fixed stretch of carrier-off time, after which the carrier is switched back on. The value of the bit is given by the bit's total length, measured from one carrier-off edge to the next, and not by a level. A 1-bit is the long period and a 0-bit is the short period. After the last data bit, one more carrier-off stretch closes the frame, and the carrier then stays on.

All durations are counted in pulses of a tick-enable input, so the system clock may run at any rate above the tick rate. A host loads a data word and a bit count with a one-cycle start strobe. It then waits while busy is high. It sees a one-cycle done pulse when the frame is complete. In that same cycle the block gives a timer-restart pulse, so that a receiver further along can measure the tag's reply window from the end of the frame.

Top module: `ppe_frame_tx`

## Requirements
- R1: After reset the carrier output is high (on), and busy, done and timer_restart are all low.
- R2: Data bits are sent least-significant bit first. Bit i of the frame is data_in[i], as captured when start was accepted.
- R3: Every data bit begins with the carrier low for exactly PAUSE_TICKS (30) ticks, after which the carrier goes high. The first pause begins one clock after start is accepted.
- R4: A 1-bit lasts ONE_TICKS (150) ticks, counted from its carrier falling edge to the next carrier falling edge.
- R5: A 0-bit lasts ZERO_TICKS (90) ticks, counted from its carrier falling edge to the next carrier falling edge.
- R6: After the last data bit, the carrier is driven low for one closing pause of PAUSE_TICKS ticks and then returns high.
- R7: done and timer_restart are each high for exactly one clock, in the clock where the carrier returns high at the end of the closing pause. busy is low in that clock.
- R8: busy is high from the clock after start is accepted until the end of the closing pause.
- R9: A bit count of zero sends only the closing pause: one carrier-low interval and no data periods.
- R10: A start strobe that arrives while busy is high is ignored. The frame in progress keeps its captured data and length.
- R11: A bit count above DATA_W (16) is treated as DATA_W.
- R12: Only clocks with tick_en high advance the timing. While tick_en is low, the carrier holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-clock tick pulse that drives all duration counting |
| start | input | 1 | Start strobe; accepted only while idle |
| data_in | input | DATA_W | Frame data, sent LSB first |
| bit_count | input | LEN_W | Number of data bits (values above DATA_W are clamped) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock pulse at frame completion |
| carrier | output | 1 | Carrier control, 1 = carrier on |
| timer_restart | output | 1 | One-clock pulse that restarts the reply-window timer |

## Verification
The assertions check, on every cycle, these relations: the carrier is on whenever the block is idle; busy rises with a pause after an accepted start; busy falls only together with the done pulse; a done pulse never lasts two clocks; the carrier never changes after a clock without a tick; the period counter stays below the long-bit length; and the bit register never shifts past its length. Only the bench scenarios can show the values themselves: that the measured low widths and periods decode back to the loaded word in LSB-first order, that zero-length and over-length frames produce the right number of pauses, and that a strobe sent mid-frame leaves the decoded word unchanged.

// File: rtl/ppe_pkg.sv
package ppe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PAUSE = 2'd1,
    ST_CARRY = 2'd2,
    ST_CLOSE = 2'd3
  } ppe_state_t;

endpackage

// File: rtl/ppe_tick_counter.sv
module ppe_tick_counter #(
  parameter int CNT_W = 8,
  parameter int LIMIT = 150
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R4: the period count never reaches the long-bit length
  p_count_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(LIMIT));

endmodule

// File: rtl/ppe_shift_reg.sv
module ppe_shift_reg #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] data_in,
  input  logic [LEN_W-1:0]  len_in,
  output logic              lsb,
  output logic              last
);

  logic [DATA_W-1:0] sreg;
  logic [LEN_W-1:0]  remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg   <= '0;
      remain <= '0;
    end else if (load) begin
      sreg   <= data_in;
      remain <= len_in;
    end else if (shift) begin
      sreg   <= sreg >> 1;
      remain <= remain - 1'b1;
    end
  end

  assign lsb  = sreg[0];
  assign last = (remain == LEN_W'(1));

  // R11: a shift never happens with no bits left
  p_no_underflow_r11: assert property (@(posedge clk) disable iff (rst)
    shift |-> (remain != '0));

  // R11: a loaded length never exceeds the register width
  p_len_limit_r11: assert property (@(posedge clk) disable iff (rst)
    load |=> (remain <= LEN_W'(DATA_W)));

endmodule

// File: rtl/ppe_frame_tx.sv
module ppe_frame_tx
  import ppe_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int PAUSE_TICKS = 30,
  parameter int ONE_TICKS   = 150,
  parameter int ZERO_TICKS  = 90,
  parameter int LEN_W       = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              start,
  input  logic [DATA_W-1:0] data_in,
  input  logic [LEN_W-1:0]  bit_count,
  output logic              busy,
  output logic              done,
  output logic              carrier,
  output logic              timer_restart
);

  localparam int LONG_TICKS = (ONE_TICKS > ZERO_TICKS) ? ONE_TICKS : ZERO_TICKS;
  localparam int CNT_W      = $clog2(LONG_TICKS + 1);
  localparam logic [CNT_W-1:0] PAUSE_END = CNT_W'(PAUSE_TICKS - 1);
  localparam logic [CNT_W-1:0] ONE_END   = CNT_W'(ONE_TICKS - 1);
  localparam logic [CNT_W-1:0] ZERO_END  = CNT_W'(ZERO_TICKS - 1);

  ppe_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [LEN_W-1:0] len_lim;
  logic             accept;
  logic             pause_hit;
  logic             bit_hit;
  logic             shift_en;
  logic             cnt_clr;
  logic             cur_bit;
  logic             last_bit;

  always_comb begin
    len_lim = (bit_count > LEN_W'(DATA_W)) ? LEN_W'(DATA_W) : bit_count;
  end

  assign accept    = start && (state == ST_IDLE);
  assign pause_hit = tick_en && (cnt == PAUSE_END);
  assign bit_hit   = tick_en && (cnt == (cur_bit ? ONE_END : ZERO_END));
  assign shift_en  = (state == ST_CARRY) && bit_hit;
  assign cnt_clr   = (state == ST_IDLE) || shift_en;

  ppe_tick_counter #(
    .CNT_W (CNT_W),
    .LIMIT (LONG_TICKS)
  ) i_counter (
    .clk  (clk),
    .rst  (rst),
    .clr  (cnt_clr),
    .tick (tick_en),
    .cnt  (cnt)
  );

  ppe_shift_reg #(
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W)
  ) i_shift (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .shift   (shift_en),
    .data_in (data_in),
    .len_in  (len_lim),
    .lsb     (cur_bit),
    .last    (last_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      busy          <= 1'b0;
      done          <= 1'b0;
      carrier       <= 1'b1;
      timer_restart <= 1'b0;
    end else begin
      done          <= 1'b0;
      timer_restart <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            busy    <= 1'b1;
            carrier <= 1'b0;
            state   <= (len_lim == '0) ? ST_CLOSE : ST_PAUSE;
          end
        end
        ST_PAUSE: begin
          if (pause_hit) begin
            carrier <= 1'b1;
            state   <= ST_CARRY;
          end
        end
        ST_CARRY: begin
          if (bit_hit) begin
            carrier <= 1'b0;
            state   <= last_bit ? ST_CLOSE : ST_PAUSE;
          end
        end
        ST_CLOSE: begin
          if (pause_hit) begin
            carrier       <= 1'b1;
            busy          <= 1'b0;
            done          <= 1'b1;
            timer_restart <= 1'b1;
            state         <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: carrier stays on whenever no frame is in progress
  p_idle_carrier_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> carrier);

  // R8: an accepted start raises busy and opens a pause
  p_busy_on_start_r8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !carrier));

  // R7: busy ends only together with the completion pulse
  p_fall_busy_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done && timer_restart && carrier));

  // R7: completion pulses last a single clock
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && !timer_restart);

  // R12: inside a frame, the carrier moves only after a tick
  p_stall_r12: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && !$past(tick_en)) |-> $stable(carrier));

  // R10: a strobe during a frame does not end or restart it
  p_ignore_start_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !tick_en) |=> busy);

endmodule

// File: tb/test_ppe_frame_tx.sv
module test_ppe_frame_tx;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        start = 1'b0;
  logic [15:0] data_in = '0;
  logic [4:0]  bit_count = '0;
  logic        busy, done, carrier, timer_restart;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int tick_mode = 0;
  bit stall = 0;
  bit finished = 0;
  logic [7:0] lfsr = 8'h5a;

  always #2 clk = ~clk;

  ppe_frame_tx i_ppe_frame_tx (
    .clk(clk), .rst(rst), .tick_en(tick_en), .start(start),
    .data_in(data_in), .bit_count(bit_count), .busy(busy), .done(done),
    .carrier(carrier), .timer_restart(timer_restart)
  );

  // tick generator
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (stall) tick_en = 1'b0;
    else if (tick_mode == 0) tick_en = 1'b1;
    else if (tick_mode == 1) tick_en = (cycles % 3 == 0);
    else tick_en = lfsr[0];
  end

  // behavioural reference model (countdown of ticks per phase)
  int m_phase = 0;
  int m_left = 0;
  bit m_car = 1, m_busy = 0, m_done = 0, m_rs = 0;
  bit m_bits[$];
  always @(posedge clk) begin
    cycles++;
    m_done = 0;
    m_rs = 0;
    if (rst) begin
      m_phase = 0; m_car = 1; m_busy = 0; m_bits.delete();
    end else begin
      case (m_phase)
        0: if (start) begin
             int n;
             n = (bit_count > 16) ? 16 : bit_count;
             m_bits.delete();
             for (int i = 0; i < n; i++) m_bits.push_back(data_in[i]);
             m_car = 0; m_busy = 1; m_left = 30;
             m_phase = (n > 0) ? 1 : 3;
           end
        1: if (tick_en) begin
             m_left--;
             if (m_left == 0) begin
               m_car = 1;
               m_left = (m_bits[0] ? 150 : 90) - 30;
               m_phase = 2;
             end
           end
        2: if (tick_en) begin
             m_left--;
             if (m_left == 0) begin
               void'(m_bits.pop_front());
               m_car = 0; m_left = 30;
               m_phase = (m_bits.size() > 0) ? 1 : 3;
             end
           end
        default: if (tick_en) begin
             m_left--;
             if (m_left == 0) begin
               m_car = 1; m_busy = 0; m_done = 1; m_rs = 1; m_phase = 0;
             end
           end
      endcase
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      checks++;
      if (carrier !== m_car) begin
        errors++; $display("FAIL R3 carrier=%0b expected %0b at cycle %0d", carrier, m_car, cycles);
      end
      if (busy !== m_busy) begin
        errors++; $display("FAIL R8 busy=%0b expected %0b at cycle %0d", busy, m_busy, cycles);
      end
      if (done !== m_done) begin
        errors++; $display("FAIL R7 done=%0b expected %0b at cycle %0d", done, m_done, cycles);
      end
      if (timer_restart !== m_rs) begin
        errors++; $display("FAIL R7 timer_restart=%0b expected %0b at cycle %0d", timer_restart, m_rs, cycles);
      end
    end
  end

  // waveform observer: carrier-low widths and fall-to-fall periods in ticks
  int lows[$];
  int pers[$];
  int low_c = 0, per_c = 0;
  bit started = 0;
  bit prev_car = 1;
  always @(negedge clk) begin
    if (!rst) begin
      if (!carrier && prev_car) begin
        if (started) pers.push_back(per_c);
        started = 1; per_c = 0; low_c = 0;
      end
      if (carrier && !prev_car) lows.push_back(low_c);
      if (tick_en && !carrier) low_c++;
      if (tick_en && started) per_c++;
      prev_car = carrier;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic launch(input logic [15:0] d, input logic [4:0] n);
    lows.delete(); pers.delete(); started = 0;
    @(posedge clk); #1;
    start = 1; data_in = d; bit_count = n;
    @(posedge clk); #1;
    start = 0; data_in = ~d;
  endtask

  task automatic finish_frame(input int nbits, input logic [15:0] word);
    logic [15:0] got;
    @(negedge clk);
    while (!done) @(negedge clk);
    check(!busy && carrier && timer_restart, "R7 completion state", {busy, carrier, timer_restart}, 3'b011);
    @(negedge clk);
    check(!done && !timer_restart, "R7 single-cycle pulse", {done, timer_restart}, 0);
    check(lows.size() == nbits + 1, "R9 R11 pause count", lows.size(), nbits + 1);
    check(pers.size() == nbits, "R11 period count", pers.size(), nbits);
    foreach (lows[i]) check(lows[i] == 30, (i == nbits) ? "R6 closing pause" : "R3 bit pause", lows[i], 30);
    got = '0;
    foreach (pers[i]) begin
      if (word[i]) check(pers[i] == 150, "R4 one-bit period", pers[i], 150);
      else check(pers[i] == 90, "R5 zero-bit period", pers[i], 90);
      if (i < 16 && pers[i] == 150) got[i] = 1'b1;
    end
    if (nbits < 16) word = word & ((16'h1 << nbits) - 1);
    check(got == word, "R2 decoded LSB-first word", got, word);
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cycles > 190000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1 reset state
    check(carrier && !busy && !done && !timer_restart, "R1 reset state",
          {carrier, busy, done, timer_restart}, 4'b1000);

    tick_mode = 0;
    launch(16'hA5C3, 5'd16);
    finish_frame(16, 16'hA5C3);

    tick_mode = 1;
    launch(16'h0055, 5'd7);
    finish_frame(7, 16'h0055);

    // R9 zero-length frame
    tick_mode = 2;
    launch(16'hFFFF, 5'd0);
    finish_frame(0, 16'h0000);

    // R11 over-length count clamps to 16
    tick_mode = 0;
    launch(16'h3B81, 5'd20);
    finish_frame(16, 16'h3B81);

    // R10 strobe during a frame is ignored
    tick_mode = 0;
    launch(16'h003B, 5'd6);
    repeat (200) @(posedge clk);
    #1 start = 1; data_in = 16'hFFC0; bit_count = 5'd16;
    @(posedge clk); #1 start = 0;
    finish_frame(6, 16'h003B);

    // R12 stall holds the carrier
    tick_mode = 2;
    launch(16'h00F0, 5'd8);
    repeat (300) @(posedge clk);
    #1 stall = 1;
    repeat (2) @(negedge clk);
    begin
      logic held;
      held = carrier;
      repeat (60) @(negedge clk);
      check(carrier == held && busy, "R12 carrier held without ticks", carrier, held);
    end
    @(posedge clk); #1 stall = 0;
    finish_frame(8, 16'h00F0);

    // R1 idle after frames, start back to back
    @(negedge clk);
    check(carrier && !busy, "R1 idle after frame", {carrier, busy}, 2'b10);
    launch(16'h0001, 5'd1);
    finish_frame(1, 16'h0001);

    repeat (5) @(posedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule